// File: doc/BRIEF.md
# Wait-State Memory Bus Cycle Controller

This block drives the external memory bus of a small 8-bit processor core. A free-running two-bit phase counter splits time into microcycles of four internal clocks. The first two clocks form the phase-1 half and the last two form the phase-2 half. Two complementary phase outputs follow this counter, so each one toggles at a quarter of the internal clock rate with an exact 50% duty cycle. An access always starts on a microcycle boundary. It can only be lengthened by whole microcycles, so the phase outputs never lose their symmetry.

The core raises a request with an address, write data, a direction bit and a flag that marks vector-area accesses, and it holds the request until a one-clock done pulse returns. A static minimum-wait setting adds extra microcycles: zero suits fast static RAM and one suits slower flash. A ready input from the addressed device can add more microcycles. Every pin on the memory side comes from a flip-flop: the address, the data out with its drive enable, a read enable, a write strobe and both phase outputs. A write-protect pin blocks the write strobe for vector-area writes. Writes to the boot address window are allowed only while a boot write-enable bit from the core is set.

Top module: `wsBusCtrl`

## Requirements
- R1: `phi1` and `phi2` are always complementary. Each one stays high for two clocks and then low for two clocks without a break. In reset `phi1`=1 and `phi2`=0. `phi1` is high in the first two clocks of a microcycle.
- R2: A held request is accepted only on a microcycle boundary. Acceptance is seen as `memRdEn` or `memDoe` rising while `phi1` has just gone high.
- R3: An access lasts (max(`minWait`, W)+1) microcycles, where W is the number of low `ready` samples, as defined in R4. `memRdEn` or `memDoe` is high for exactly four times that many clocks.
- R4: `ready` is sampled once per microcycle, on the clock that ends the phase-1 half. A low sample, or one taken before `minWait` extra microcycles have passed, adds exactly one more full microcycle.
- R5: `memAddr`, and `memDout` on writes, stay stable for the whole access.
- R6: A read (`reqWrite`=0) asserts only `memRdEn`. A write (`reqWrite`=1) asserts only `memDoe`. The two are never high together.
- R7: A permitted write asserts `memWrStb` for exactly one clock, the third clock of the final microcycle. The strobe is low in the last clock, while the address is still held.
- R8: On the last clock of a read, `memDin` is captured into `rdData`. `done` is high for exactly one clock right after that edge, and it pulses for writes too.
- R9: A write flagged with `reqVec`=1 while `wpIn`=1 produces no write strobe but still completes with `done`. When `wpIn`=0, or for writes without the flag, the strobe is produced normally.
- R10: A write whose address lies in [`BOOT_LO`,`BOOT_HI`] produces no strobe unless `bootWrEn`=1. It still completes with `done`.
- R11: While no access is in progress, changes on `ready` have no effect: no enable, strobe or `done` appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | internal clock, four times the bus rate |
| rstN | input | 1 | active-low synchronous reset |
| reqValid | input | 1 | access request, held until `done` |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqVec | input | 1 | access targets the vector area |
| reqAddr | input | ADDR_W | access address |
| reqWrData | input | DATA_W | write data |
| minWait | input | WAIT_W | minimum extra microcycles |
| bootWrEn | input | 1 | permits writes to the boot window |
| wpIn | input | 1 | write-protect pin for the vector area |
| ready | input | 1 | device ready, low stretches the access |
| memDin | input | DATA_W | read data from memory |
| rdData | output | DATA_W | captured read data |
| done | output | 1 | one-clock completion pulse |
| memAddr | output | ADDR_W | registered address bus |
| memDout | output | DATA_W | registered write data |
| memDoe | output | 1 | data bus drive enable (writes) |
| memRdEn | output | 1 | read enable |
| memWrStb | output | 1 | write strobe |
| phi1 | output | 1 | phase-1 clock output |
| phi2 | output | 1 | phase-2 clock output |

## Verification
The hardest case to reach from the ports is a stretched access in which the minimum-wait setting and the ready input disagree. For example, `ready` may go high before the minimum has been served, or stay low past it. Both must extend the access by whole microcycles, and the single write strobe must still land in the final one. The stimulus finds the accept edge by watching the enables rise. From there it counts clocks and drives `ready` low for exactly the first W sampling points. A sweep over every pairing of minimum wait 0–3 and W 0–3 for both directions covers every order in which the two conditions resolve.

// File: rtl/wsBusPkg.sv
`timescale 1ns/1ps
package wsBusPkg;
  localparam int PH_W = 2;
  localparam int MC_CLKS = 1 << PH_W;

  typedef struct packed {
    logic load;     // accept request at microcycle boundary
    logic finish;   // last clock of final microcycle
    logic stbSet;   // final microcycle decided, raise strobe next
    logic stbClr;   // phase-2 first clock ends, drop strobe
    logic phi1D;    // next value of phase-1 output
    logic phi2D;    // next value of phase-2 output
  } busStrb_t;
endpackage

// File: rtl/wsBusCtl.sv
`timescale 1ns/1ps
module wsBusCtl
  import wsBusPkg::*;
#(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              ready,
  input  logic [WAIT_W-1:0] minWait,
  output busStrb_t          strb
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(MC_CLKS - 1);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(MC_CLKS / 2 - 1);
  localparam logic [PH_W-1:0] PH_P2   = PH_W'(MC_CLKS / 2);

  logic [PH_W-1:0]   ph;
  logic              busy;
  logic              lastMc;
  logic [WAIT_W-1:0] mcCnt;
  logic [WAIT_W-1:0] minWaitQ;
  logic              accept;
  logic              finalNow;

  always_comb begin
    accept       = !busy && reqValid && (ph == PH_LAST);
    finalNow     = (mcCnt >= minWaitQ) && ready;
    strb.load    = accept;
    strb.finish  = busy && (ph == PH_LAST) && lastMc;
    strb.stbSet  = busy && (ph == PH_MID) && finalNow;
    strb.stbClr  = (ph == PH_P2);
    strb.phi1D   = (ph == PH_LAST) || (ph < PH_MID);
    strb.phi2D   = (ph >= PH_MID) && (ph != PH_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ph       <= '0;
      busy     <= 1'b0;
      lastMc   <= 1'b0;
      mcCnt    <= '0;
      minWaitQ <= '0;
    end else begin
      ph <= ph + 1'b1;
      if (accept) begin
        busy     <= 1'b1;
        lastMc   <= 1'b0;
        mcCnt    <= '0;
        minWaitQ <= minWait;
      end else if (busy) begin
        if (ph == PH_MID) lastMc <= finalNow;
        if (ph == PH_LAST) begin
          if (lastMc) begin
            busy   <= 1'b0;
            lastMc <= 1'b0;
          end else if (mcCnt != '1) begin
            mcCnt <= mcCnt + 1'b1;
          end
        end
      end
    end
  end

  AST_START_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (ph == '0)); // R2
  AST_FINISH_AFTER_MIN: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |-> (mcCnt >= minWaitQ)); // R3
  AST_STRETCH_WHOLE_MC: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (ph == '0)); // R4
endmodule

// File: rtl/wsBusDp.sv
`timescale 1ns/1ps
module wsBusDp
  import wsBusPkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int BOOT_LO = 'hF800,
  parameter int BOOT_HI = 'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrb_t          strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic              reqWrite,
  input  logic              reqVec,
  input  logic              wpIn,
  input  logic              bootWrEn,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memRdEn,
  output logic              memDoe,
  output logic              memWrStb,
  output logic              phi1,
  output logic              phi2,
  output logic [DATA_W-1:0] rdData,
  output logic              done
);
  localparam logic [ADDR_W-1:0] BOOT_LO_A = ADDR_W'(BOOT_LO);
  localparam logic [ADDR_W-1:0] BOOT_HI_A = ADDR_W'(BOOT_HI);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] doutQ, rdDataQ;
  logic rdEnQ, doeQ, wrStbQ, doneQ, phi1Q, phi2Q;
  logic vecQ, wpQ, bootHitQ, bootOkQ;
  logic inBoot, blocked;

  always_comb begin
    inBoot  = (reqAddr >= BOOT_LO_A) && (reqAddr <= BOOT_HI_A);
    blocked = (vecQ && wpQ) || (bootHitQ && !bootOkQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phi1Q    <= 1'b1;
      phi2Q    <= 1'b0;
      addrQ    <= '0;
      doutQ    <= '0;
      rdDataQ  <= '0;
      rdEnQ    <= 1'b0;
      doeQ     <= 1'b0;
      wrStbQ   <= 1'b0;
      doneQ    <= 1'b0;
      vecQ     <= 1'b0;
      wpQ      <= 1'b0;
      bootHitQ <= 1'b0;
      bootOkQ  <= 1'b0;
    end else begin
      phi1Q <= strb.phi1D;
      phi2Q <= strb.phi2D;
      doneQ <= strb.finish;
      if (strb.load) begin
        addrQ    <= reqAddr;
        doutQ    <= reqWrData;
        rdEnQ    <= !reqWrite;
        doeQ     <= reqWrite;
        vecQ     <= reqVec;
        wpQ      <= wpIn;
        bootHitQ <= inBoot;
        bootOkQ  <= bootWrEn;
      end else if (strb.finish) begin
        rdEnQ <= 1'b0;
        doeQ  <= 1'b0;
      end
      if (strb.finish && rdEnQ) rdDataQ <= memDin;
      if (strb.stbSet && doeQ && !blocked) wrStbQ <= 1'b1;
      else if (strb.stbClr)                wrStbQ <= 1'b0;
    end
  end

  assign memAddr  = addrQ;
  assign memDout  = doutQ;
  assign memRdEn  = rdEnQ;
  assign memDoe   = doeQ;
  assign memWrStb = wrStbQ;
  assign phi1     = phi1Q;
  assign phi2     = phi2Q;
  assign rdData   = rdDataQ;
  assign done     = doneQ;

  AST_PHI_COMPLEMENT: assert property (@(posedge clk) disable iff (!rstN)
    phi1Q != phi2Q); // R1
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    ((rdEnQ || doeQ) && $past(rdEnQ || doeQ)) |-> $stable(addrQ)); // R5
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEnQ && doeQ)); // R6
  AST_STB_ONE_CLK: assert property (@(posedge clk) disable iff (!rstN)
    wrStbQ |=> !wrStbQ); // R7
  AST_STB_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrStbQ |-> (doeQ && phi2Q)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ); // R8
  AST_VEC_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    wrStbQ |-> !(vecQ && wpQ)); // R9
  AST_BOOT_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    wrStbQ |-> !(bootHitQ && !bootOkQ)); // R10
endmodule

// File: rtl/wsBusCtrl.sv
`timescale 1ns/1ps
module wsBusCtrl
  import wsBusPkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int WAIT_W  = 2,
  parameter int BOOT_LO = 'hF800,
  parameter int BOOT_HI = 'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqVec,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [WAIT_W-1:0] minWait,
  input  logic              bootWrEn,
  input  logic              wpIn,
  input  logic              ready,
  input  logic [DATA_W-1:0] memDin,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoe,
  output logic              memRdEn,
  output logic              memWrStb,
  output logic              phi1,
  output logic              phi2
);
  busStrb_t strb;

  wsBusCtl #(.WAIT_W(WAIT_W)) i_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .ready(ready),
    .minWait(minWait), .strb(strb)
  );

  wsBusDp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_LO(BOOT_LO), .BOOT_HI(BOOT_HI)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqWrData(reqWrData), .reqWrite(reqWrite), .reqVec(reqVec),
    .wpIn(wpIn), .bootWrEn(bootWrEn), .memDin(memDin),
    .memAddr(memAddr), .memDout(memDout), .memRdEn(memRdEn),
    .memDoe(memDoe), .memWrStb(memWrStb), .phi1(phi1), .phi2(phi2),
    .rdData(rdData), .done(done)
  );
endmodule

// File: tb/test_wsBusCtrl.sv
`timescale 1ns/1ps
module test_wsBusCtrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqVec = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0] reqWrData = '0;
  logic [1:0] minWait = '0;
  logic bootWrEn = 1'b0, wpIn = 1'b0, ready = 1'b0;
  logic [7:0] memDin, rdData, memDout;
  logic done, memDoe, memRdEn, memWrStb, phi1, phi2;
  logic [15:0] memAddr;

  int nChecks = 0;
  int nFails = 0;
  int phaseErr = 0;
  bit phaseArmed = 1'b0;

  always #2 clk = ~clk;

  assign memDin = memAddr[7:0] ^ memAddr[15:8] ^ 8'hA5;

  wsBusCtrl i_wsBusCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqVec(reqVec), .reqAddr(reqAddr), .reqWrData(reqWrData),
    .minWait(minWait), .bootWrEn(bootWrEn), .wpIn(wpIn), .ready(ready),
    .memDin(memDin), .rdData(rdData), .done(done), .memAddr(memAddr),
    .memDout(memDout), .memDoe(memDoe), .memRdEn(memRdEn),
    .memWrStb(memWrStb), .phi1(phi1), .phi2(phi2)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // R1 phase monitor: complementary, runs of exactly two clocks
  logic prevPhi1 = 1'b1;
  int runLen = 0;
  bit seenToggle = 1'b0;
  always @(negedge clk) begin
    if (phaseArmed) begin
      if (phi1 == phi2) phaseErr++;
      if (phi1 != prevPhi1) begin
        if (seenToggle && runLen != 2) phaseErr++;
        seenToggle = 1'b1;
        runLen = 1;
      end else begin
        runLen++;
      end
      prevPhi1 = phi1;
    end
  end

  task automatic access(input logic [15:0] a, input bit wr, input logic [7:0] d,
                        input bit vec, input bit wp, input bit bEn,
                        input int mw, input int w, input bit expStb);
    int j, activeLen, stbCnt, stbAt, addrBad, doutBad, bothBad, m;
    bit boundaryOk;
    m = ((mw > w) ? mw : w) + 1;
    @(negedge clk);
    reqAddr = a; reqWrite = wr; reqWrData = d; reqVec = vec; wpIn = wp;
    bootWrEn = bEn; minWait = 2'(mw); ready = 1'b0; reqValid = 1'b1;
    while (!(memRdEn || memDoe)) @(negedge clk);
    boundaryOk = phi1 && !phi2;
    j = 0; activeLen = 0; stbCnt = 0; stbAt = -1; addrBad = 0; doutBad = 0; bothBad = 0;
    while (memRdEn || memDoe) begin
      activeLen++;
      if (memAddr != a) addrBad++;
      if (wr && memDout != d) doutBad++;
      if (memRdEn && memDoe) bothBad++;
      if (wr && !memDoe) bothBad++;
      if (!wr && !memRdEn) bothBad++;
      if (done) bothBad++;
      if (memWrStb) begin stbCnt++; stbAt = j; end
      ready = (j > 4 * w);
      @(negedge clk);
      j++;
    end
    check(boundaryOk, "R2 accept on boundary", int'(boundaryOk), 1);
    check(activeLen == 4 * m, "R3/R4 access length", activeLen, 4 * m);
    check(addrBad == 0 && doutBad == 0, "R5 addr/data stable", addrBad + doutBad, 0);
    check(bothBad == 0, "R6 enable selection", bothBad, 0);
    if (expStb) begin
      check(stbCnt == 1, "R7 strobe count", stbCnt, 1);
      check(stbAt == 4 * m - 2, "R7 strobe position", stbAt, 4 * m - 2);
    end else begin
      check(stbCnt == 0, "R9/R10 strobe suppressed", stbCnt, 0);
    end
    check(done == 1'b1, "R8 done after last clock", int'(done), 1);
    if (!wr) check(rdData == (a[7:0] ^ a[15:8] ^ 8'hA5), "R8 read data",
                   int'(rdData), int'(a[7:0] ^ a[15:8] ^ 8'hA5));
    reqValid = 1'b0; ready = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R8 done one clock", int'(done), 0);
  endtask

  initial begin
    #600000;
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    check(phi1 && !phi2, "R1 reset phases", int'({phi1, phi2}), 2);
    check(!memRdEn && !memDoe && !memWrStb && !done, "R1 reset outputs",
          int'({memRdEn, memDoe, memWrStb, done}), 0);
    rstN = 1'b1;
    phaseArmed = 1'b1;

    // R3 R4 R5 R6 R7 R8: sweep minimum wait against ready delay, both directions
    for (int mw = 0; mw < 4; mw++)
      for (int w = 0; w < 4; w++)
        for (int wr = 0; wr < 2; wr++)
          access(16'h1000 + 16'(mw * 293 + w * 37 + wr * 5), wr[0],
                 8'(mw * 16 + w * 4 + wr + 8'h30), 1'b0, 1'b0, 1'b0, mw, w, wr[0]);

    // R9: vector guard
    access(16'hFFFA - 16'h0800, 1'b1, 8'h11, 1'b1, 1'b1, 1'b1, 0, 0, 1'b0);
    access(16'hFFFA - 16'h0800, 1'b1, 8'h22, 1'b1, 1'b0, 1'b1, 1, 0, 1'b1);
    access(16'h2345, 1'b1, 8'h33, 1'b0, 1'b1, 1'b0, 0, 1, 1'b1);
    // R10: boot window guard, both edges of the window
    access(16'hF800, 1'b1, 8'h44, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0);
    access(16'hFFFF, 1'b1, 8'h55, 1'b0, 1'b0, 1'b0, 1, 2, 1'b0);
    access(16'hF800, 1'b1, 8'h66, 1'b0, 1'b0, 1'b1, 0, 0, 1'b1);
    access(16'hF7FF, 1'b1, 8'h77, 1'b0, 1'b0, 1'b0, 0, 0, 1'b1);
    access(16'hF900, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1, 0, 1'b0);

    // R11: ready toggling while idle
    begin
      int act = 0;
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        ready = k[0];
        if (memRdEn || memDoe || memWrStb || done) act++;
      end
      ready = 1'b0;
      check(act == 0, "R11 idle ready ignored", act, 0);
    end

    check(phaseErr == 0 && seenToggle, "R1 phase duty", phaseErr, 0);
    summary();
  end
endmodule